// File: doc/BRIEF.md
# Handshaked ADC Conversion Controller

This block sequences a slow successive-approximation analog-to-digital converter through its start and end-of-conversion handshake and presents each 8-bit result to a simple byte-wide host bus. A host write to the data port asks for one sample. The controller selects the converter, pulses its active-low write strobe to start a conversion, waits for completion, pulses the active-low read strobe, and captures the converter's output byte into a result register. A status port reports whether a conversion is running and whether an unread result is waiting. An optional level interrupt goes high while a result is waiting.

Completion is detected in one of two ways, chosen by a mode input when a request is accepted. In poll mode the controller synchronizes the converter's active-low end-of-conversion line and starts the read once that line goes low. In delay mode it ignores that line and waits a fixed worst-case interval. The interval is derived from the system clock frequency and the maximum conversion time. The block also divides the system clock down to produce the converter's clock, which must stay between 100 kHz and 1460 kHz.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After synchronous reset, adc_cs_n, adc_wr_n and adc_rd_n are high, irq is low, and reads of the status port and of the data port both return 0.
- R2: A host write to address DATA_ADDR (default 8'h40) is accepted when the controller is idle and holds no unread result. After acceptance, adc_cs_n goes low for one cycle with both strobes high. Then adc_wr_n is low for exactly WR_CYC cycles. adc_cs_n stays low until the read strobe ends.
- R3: In poll mode (mode_delay = 0 at acceptance), adc_rd_n falls only after adc_intr_n has been seen low. The delay is three clock edges through a two-stage synchronizer, so a bench that samples mid-cycle sees adc_rd_n low two samples after adc_intr_n first reads low. There is no timeout.
- R4: In delay mode (mode_delay = 1 at acceptance), adc_rd_n falls exactly DELAY_CYC = (SYS_CLK_HZ / 1,000,000) × CONV_US cycles after adc_wr_n rises, whatever adc_intr_n does. DELAY_CYC is 1000 with the defaults.
- R5: A start request made while a conversion runs, or while an unread result is held, is ignored. No second write strobe is issued, and adc_cs_n stays high while a result is unread.
- R6: adc_rd_n is low for exactly RD_CYC cycles. adc_data is captured on the last of those cycles, and adc_cs_n is high in the cycle after.
- R7: A host read of DATA_ADDR returns the captured byte and clears the ready flag. A read of STAT_ADDR (default 8'h42) returns bit 0 = result ready and bit 1 = busy, with all other bits 0. A read of any other address, or with host_rd low, returns 0.
- R8: irq is high exactly when a result is ready and irq_en is high.
- R9: adc_clk toggles every HALF_DIV = SYS_CLK_HZ / (2 × ADC_CLK_HZ) cycles (5 with the defaults, a 1 MHz converter clock).
- R10: The completion mode is latched when a request is accepted. Changing mode_delay during a conversion does not change how that conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe; a write to DATA_ADDR requests a conversion |
| host_rd | input | 1 | Host read strobe; a read of DATA_ADDR consumes the result |
| host_rdata | output | 8 | Read data (combinational from host_addr and host_rd) |
| mode_delay | input | 1 | 1 = fixed-delay completion, 0 = poll end-of-conversion |
| irq_en | input | 1 | Enables irq when a result is ready |
| irq | output | 1 | Level interrupt request |
| adc_clk | output | 1 | Divided clock for the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_wr_n | output | 1 | Conversion start strobe, active low |
| adc_rd_n | output | 1 | Result read strobe, active low |
| adc_intr_n | input | 1 | End-of-conversion from the converter, active low |
| adc_data | input | 8 | Converter output byte |

## Verification
The assertions check four timing properties on every cycle. In poll mode a read never starts without the end-of-conversion line having been low three edges before. In delay mode the gap from write strobe to read strobe always equals the configured interval. The read strobe always has its programmed width, and the converter clock half-period never varies. They also check that the converter is never selected while a result is unread, and that a data-port read drops the ready flag. Other behaviours can only be shown by the bench's scenarios: correct data capture, status and interrupt values across a full transaction, rejection of repeated start requests, and the mode being latched at acceptance. These need a converter model and host transactions to show.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    // Sequencer states, in the order a transaction walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_STRB  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_READ  = 3'd4
    } seq_state_e;

    // Active-low converter control lines.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
    } adc_strobe_t;

    // Status byte seen by the host.
    typedef struct packed {
        logic [5:0] rsvd;
        logic       busy;
        logic       ready;
    } status_t;

    // Decoded host access for one cycle.
    typedef struct packed {
        logic start;
        logic rd_data;
        logic rd_status;
    } host_req_t;

    // Cycles of system clock covering the worst-case conversion time.
    function automatic int unsigned delay_cycles(input int unsigned sys_hz,
                                                 input int unsigned conv_us);
        return (sys_hz / 1000000) * conv_us;
    endfunction

    // System clock cycles per converter clock half-period (at least 1).
    function automatic int unsigned half_div(input int unsigned sys_hz,
                                             input int unsigned adc_hz);
        int unsigned h;
        h = sys_hz / (2 * adc_hz);
        return (h < 1) ? 1 : h;
    endfunction

    // Bits needed to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Strobe levels for each sequencer state.
    function automatic adc_strobe_t drive_of(input seq_state_e s);
        adc_strobe_t o;
        o.cs_n = 1'b1;
        o.wr_n = 1'b1;
        o.rd_n = 1'b1;
        case (s)
            ST_SETUP, ST_WAIT: o.cs_n = 1'b0;
            ST_STRB: begin
                o.cs_n = 1'b0;
                o.wr_n = 1'b0;
            end
            ST_READ: begin
                o.cs_n = 1'b0;
                o.rd_n = 1'b0;
            end
            default: o.cs_n = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // Resets to 1: the synchronized line is active low.
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adcc_timer.sv
module adcc_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    // A load of N makes done rise N cycles later, so a phase entered with
    // that load lasts exactly N cycles (N >= 1).
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val - W'(1);
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/adcc_clkdiv.sv
module adcc_clkdiv
    import adcc_pkg::*;
#(
    parameter int unsigned HALF = 5
) (
    input  logic clk,
    input  logic rst,
    output logic div_clk
);
    localparam int unsigned CW = cnt_width(HALF);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_clk <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt     <= '0;
            div_clk <= ~div_clk;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Independent run-length watcher for the half-period.
    logic [CW-1:0] chk_run;
    logic          chk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_run  <= '0;
            chk_prev <= 1'b0;
        end else begin
            chk_prev <= div_clk;
            chk_run  <= (div_clk != chk_prev) ? CW'(1) : chk_run + CW'(1);
        end
    end

    assert_half_period_R9: assert property (@(posedge clk) disable iff (rst)
        (div_clk != chk_prev) |-> (chk_run == CW'(HALF)));
endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
    import adcc_pkg::*;
#(
    parameter int unsigned WR_CYC      = 4,
    parameter int unsigned RD_CYC      = 3,
    parameter int unsigned DELAY_CYC   = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        mode_delay,
    input  logic        intr_n,
    output adc_strobe_t strb,
    output logic        busy,
    output logic        capture,
    output logic        delay_q
);
    localparam int unsigned TW = cnt_width(max3(WR_CYC, RD_CYC, DELAY_CYC));

    seq_state_e    st, st_nx;
    logic          tm_load;
    logic [TW-1:0] tm_val;
    logic          tm_done;
    logic          eoc_n;

    adcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (intr_n),
        .q   (eoc_n)
    );

    // One counter serves the write strobe, the fixed wait and the read strobe.
    adcc_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .done     (tm_done)
    );

    always_comb begin
        st_nx   = st;
        tm_load = 1'b0;
        tm_val  = '0;
        capture = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) st_nx = ST_SETUP;
            end
            ST_SETUP: begin
                st_nx   = ST_STRB;
                tm_load = 1'b1;
                tm_val  = TW'(WR_CYC);
            end
            ST_STRB: begin
                if (tm_done) begin
                    st_nx   = ST_WAIT;
                    tm_load = 1'b1;
                    tm_val  = TW'(DELAY_CYC);
                end
            end
            ST_WAIT: begin
                if (delay_q ? tm_done : !eoc_n) begin
                    st_nx   = ST_READ;
                    tm_load = 1'b1;
                    tm_val  = TW'(RD_CYC);
                end
            end
            ST_READ: begin
                if (tm_done) begin
                    st_nx   = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            delay_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && start) delay_q <= mode_delay;
        end
    end

    assign strb = drive_of(st);
    assign busy = (st != ST_IDLE);

    // Poll mode: a read begins only when the raw line was low three edges ago.
    assert_eoc_before_read_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.rd_n) && !delay_q) |-> !$past(intr_n, 3));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adcc_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 10000000,
    parameter int unsigned ADC_CLK_HZ = 1000000,
    parameter int unsigned CONV_US    = 100,
    parameter int unsigned WR_CYC     = 4,
    parameter int unsigned RD_CYC     = 3,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic              mode_delay,
    input  logic              irq_en,
    output logic              irq,
    output logic              adc_clk,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    input  logic              adc_intr_n,
    input  logic [7:0]        adc_data
);
    localparam int unsigned DELAY_CYC = delay_cycles(SYS_CLK_HZ, CONV_US);
    localparam int unsigned HALF_DIV  = half_div(SYS_CLK_HZ, ADC_CLK_HZ);
    localparam int unsigned GW        = cnt_width(DELAY_CYC + 1);
    localparam int unsigned RW        = cnt_width(RD_CYC + 1);

    host_req_t   req;
    adc_strobe_t strb;
    status_t     stat;
    logic        busy, capture, delay_q, start_ok;
    logic        ready_q;
    logic [7:0]  result_q;

    // Host decode: the data port both starts and consumes.
    always_comb begin
        req.start     = host_wr && (host_addr == DATA_ADDR);
        req.rd_data   = host_rd && (host_addr == DATA_ADDR);
        req.rd_status = host_rd && (host_addr == STAT_ADDR);
    end

    assign start_ok = req.start && !busy && !ready_q;

    adcc_seq #(
        .WR_CYC      (WR_CYC),
        .RD_CYC      (RD_CYC),
        .DELAY_CYC   (DELAY_CYC),
        .SYNC_STAGES (2)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_ok),
        .mode_delay (mode_delay),
        .intr_n     (adc_intr_n),
        .strb       (strb),
        .busy       (busy),
        .capture    (capture),
        .delay_q    (delay_q)
    );

    adcc_clkdiv #(.HALF(HALF_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_clk (adc_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q  <= 1'b0;
            result_q <= '0;
        end else if (capture) begin
            ready_q  <= 1'b1;
            result_q <= adc_data;
        end else if (req.rd_data) begin
            ready_q  <= 1'b0;
        end
    end

    always_comb begin
        stat.rsvd  = '0;
        stat.busy  = busy;
        stat.ready = ready_q;
    end

    always_comb begin
        if (req.rd_data)        host_rdata = result_q;
        else if (req.rd_status) host_rdata = stat;
        else                    host_rdata = '0;
    end

    assign irq      = ready_q && irq_en;
    assign adc_cs_n = strb.cs_n;
    assign adc_wr_n = strb.wr_n;
    assign adc_rd_n = strb.rd_n;

    // Checker counters at the converter pins.
    logic [GW-1:0] chk_gap;
    logic [RW-1:0] chk_rdlen;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_gap   <= '0;
            chk_rdlen <= '0;
        end else begin
            if (!adc_wr_n)                    chk_gap <= '0;
            else if (chk_gap != GW'(DELAY_CYC + 1)) chk_gap <= chk_gap + GW'(1);
            if (adc_rd_n)                     chk_rdlen <= '0;
            else if (chk_rdlen != RW'(RD_CYC + 1)) chk_rdlen <= chk_rdlen + RW'(1);
        end
    end

    assert_delay_window_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_rd_n) && delay_q) |-> (chk_gap == GW'(DELAY_CYC)));

    assert_read_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_rd_n) |-> (chk_rdlen == RW'(RD_CYC)));

    assert_idle_while_unread_R5: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> adc_cs_n);

    assert_read_clears_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (ready_q && req.rd_data) |=> !ready_q);
endmodule

// File: tb/tb_adc_conv_ctrl.sv
module tb_adc_conv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned SYS_HZ  = 10000000;
    localparam int unsigned ADC_HZ  = 1000000;
    localparam int unsigned CONV_US = 100;
    localparam int unsigned WR_W    = 4;
    localparam int unsigned RD_W    = 3;
    localparam int EXP_DELAY = (SYS_HZ / 1000000) * CONV_US;
    localparam int EXP_HALF  = SYS_HZ / (2 * ADC_HZ);
    localparam logic [7:0] A_DATA = 8'h40;
    localparam logic [7:0] A_STAT = 8'h42;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] host_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_rdata;
    logic       mode_delay, irq_en, irq;
    logic       adc_clk, adc_cs_n, adc_wr_n, adc_rd_n;
    logic       adc_intr_n;
    logic [7:0] adc_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    // Converter model controls
    logic [7:0] m_sample = 8'h00;
    int         m_lat    = 10;
    bit         m_never  = 0;

    adc_conv_ctrl #(
        .SYS_CLK_HZ (SYS_HZ),
        .ADC_CLK_HZ (ADC_HZ),
        .CONV_US    (CONV_US),
        .WR_CYC     (WR_W),
        .RD_CYC     (RD_W)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .mode_delay (mode_delay),
        .irq_en     (irq_en),
        .irq        (irq),
        .adc_clk    (adc_clk),
        .adc_cs_n   (adc_cs_n),
        .adc_wr_n   (adc_wr_n),
        .adc_rd_n   (adc_rd_n),
        .adc_intr_n (adc_intr_n),
        .adc_data   (adc_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Converter model, acting on falling clock edges.
    initial begin : adc_model
        bit running;
        int cnt;
        running    = 0;
        cnt        = 0;
        adc_intr_n = 1'b1;
        adc_data   = 8'h00;
        forever begin
            @(negedge clk);
            if (adc_wr_n === 1'b0) begin
                adc_intr_n = 1'b1;
                running    = 1;
                cnt        = m_lat;
            end else if (running) begin
                if (cnt == 0) begin
                    if (!m_never) adc_intr_n = 1'b0;
                    running = 0;
                end else begin
                    cnt = cnt - 1;
                end
            end
            if (adc_rd_n === 1'b0) begin
                adc_intr_n = 1'b1;
                adc_data   = m_sample;
            end else begin
                adc_data = 8'h00;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        host_addr = a;
        host_rd   = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #2;
        host_rd = 1'b0;
    endtask

    task automatic host_start();
        @(posedge clk); #2;
        host_addr = A_DATA;
        host_wr   = 1'b1;
        @(posedge clk); #2;
        host_wr = 1'b0;
    endtask

    // One full transaction with cycle-accurate observation of the strobes.
    task automatic do_conv(input logic [7:0] smp, input bit dmode, input int lat,
                           input bit never, input bit ien, input int flip_at,
                           input int extra_at);
        int setup_n, wr_len, wr_pulses, gap, rd_len, intr_at, rdf_at, cs_gap, cyc, lows;
        bit done, prev_wr, prev_rd;
        logic [7:0] d;
        setup_n = 0; wr_len = 0; wr_pulses = 0; gap = 0; rd_len = 0;
        intr_at = -1; rdf_at = -1; cs_gap = 0; cyc = 0; lows = 0;
        done = 0; prev_wr = 1; prev_rd = 1;
        m_sample = smp; m_lat = lat; m_never = never;
        mode_delay = dmode; irq_en = ien;
        host_start();
        while (!done && cyc < 20000) begin
            host_wr = 1'b0;
            if (cyc == flip_at) mode_delay = !mode_delay;
            if (cyc == extra_at) begin
                host_addr = A_DATA;
                host_wr   = 1'b1;
            end
            if (adc_cs_n && rd_len == 0) cs_gap++;
            if (!adc_cs_n && adc_wr_n && adc_rd_n && wr_pulses == 0) setup_n++;
            if (!adc_wr_n) begin
                if (prev_wr) wr_pulses++;
                wr_len++;
            end
            if (wr_pulses > 0 && !adc_cs_n && adc_wr_n && adc_rd_n && rd_len == 0) gap++;
            if (wr_pulses > 0 && !adc_intr_n && intr_at < 0) intr_at = cyc;
            if (!adc_rd_n) begin
                if (prev_rd) rdf_at = cyc;
                rd_len++;
            end
            if (rd_len > 0 && adc_rd_n) done = 1;
            prev_wr = adc_wr_n;
            prev_rd = adc_rd_n;
            if (!done) begin
                @(posedge clk); #2;
                cyc++;
            end
        end
        host_wr = 1'b0;
        chk("R2 select-only setup cycles", setup_n, 1);
        chk("R2 write strobe width", wr_len, WR_W);
        chk("R2 select held through transaction", cs_gap, 0);
        chk("R5 single start strobe", wr_pulses, 1);
        chk("R6 read strobe width", rd_len, RD_W);
        chk("R6 select released after read", adc_cs_n, 1);
        if (dmode) chk("R4 R10 fixed wait length", gap, EXP_DELAY);
        else       chk("R3 R10 eoc-to-read latency", rdf_at - intr_at, 2);
        chk("R8 irq with result ready", irq, ien);
        host_read(A_STAT, d);
        chk("R7 status after capture", d, 8'h01);
        // Start attempt while a result is unread
        host_start();
        for (int i = 0; i < 6; i++) begin
            if (!adc_cs_n) lows++;
            @(posedge clk); #2;
        end
        chk("R5 start ignored while result unread", lows, 0);
        host_read(A_DATA, d);
        chk("R6 captured byte", d, smp);
        chk("R8 irq cleared by data read", irq, 0);
        host_read(A_STAT, d);
        chk("R7 status after data read", d, 8'h00);
    endtask

    function automatic int pick_lat(input bit dm);
        return dm ? int'($urandom_range(0, 1200)) : int'($urandom_range(0, 1300));
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R2: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int t;
        bit prev;
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; host_addr = 8'h00; host_wr = 1'b0; host_rd = 1'b0;
        mode_delay = 1'b0; irq_en = 1'b0;
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        chk("R1 cs_n after reset", adc_cs_n, 1);
        chk("R1 wr_n after reset", adc_wr_n, 1);
        chk("R1 rd_n after reset", adc_rd_n, 1);
        irq_en = 1'b1;
        #1 chk("R1 irq after reset", irq, 0);
        host_read(A_STAT, d);
        chk("R1 status after reset", d, 0);
        host_read(A_DATA, d);
        chk("R1 data after reset", d, 0);
        host_read(8'h41, d);
        chk("R7 unmapped address reads zero", d, 0);

        // R9 converter clock half-period
        prev = adc_clk;
        t = 0;
        while (adc_clk == prev && t < 100) begin @(posedge clk); #2; t++; end
        for (int k = 0; k < 2; k++) begin
            prev = adc_clk;
            t = 0;
            while (adc_clk == prev && t < 100) begin @(posedge clk); #2; t++; end
            chk("R9 converter clock half-period", t, EXP_HALF);
        end

        // R7 busy bit while a conversion runs
        m_sample = 8'h5A; m_lat = 30; m_never = 0; mode_delay = 1'b0;
        host_start();
        host_read(A_STAT, d);
        chk("R7 status while busy", d, 8'h02);
        t = 0;
        while (adc_cs_n == 1'b0 && t < 5000) begin @(posedge clk); #2; t++; end
        host_read(A_DATA, d);
        chk("R7 data port returns result", d, 8'h5A);

        // Directed corners
        do_conv(8'hA5, 0, 50,   0, 1, -1, -1);   // R3 poll
        do_conv(8'h3C, 1, 0,    1, 1, -1, -1);   // R4 eoc never arrives
        do_conv(8'hFF, 1, 3,    0, 0, -1, -1);   // R4 early eoc ignored
        do_conv(8'h00, 0, 1800, 0, 1, -1, -1);   // R3 eoc later than fixed wait
        do_conv(8'h81, 1, 20,   0, 1, 10, -1);   // R10 delay latched, flipped to poll
        do_conv(8'h7E, 0, 1500, 0, 0, 5,  -1);   // R10 poll latched, flipped to delay
        do_conv(8'h42, 0, 40,   0, 1, -1, 8);    // R5 start during strobe/wait
        do_conv(8'h24, 1, 10,   0, 1, -1, 2);    // R5 start during write strobe

        // Constrained random transactions
        for (int n = 0; n < 14; n++) begin
            bit dm;
            bit nv;
            dm = 1'($urandom_range(0, 1));
            nv = dm ? 1'($urandom_range(0, 1)) : 1'b0;
            do_conv(8'($urandom_range(0, 255)), dm, pick_lat(dm), nv,
                    1'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 30)) : -1,
                    ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 40)) : -1);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule